// File: doc/BRIEF.md
# Frame Workload Estimator with DVS Level Selection

This block forecasts how many processor cycles the next frame will need, so that a power manager can choose a clock and voltage level before the frame starts. Each time a frame finishes, the measured cycle count arrives with a one-cycle strobe. The block compares that count with its own forecast for the same frame, feeds the difference through a correction filter and produces the forecast for the following frame. The same forecast is then turned into a level index. The chosen level is the slowest one that still completes the forecast work within the frame deadline.

Three filters are available. The main one is a closed-loop controller with three terms. The first term is proportional to the latest error. The second is an average of recent errors over a window whose length is a power of two. The third is the change in error measured across a second window of the same kind. The other two filters are a plain average of recent measured workloads and an exponential smoother. Error and workload histories are kept in circular buffers. The window sum is updated incrementally, and every division is a shift.

Top module: `wl_pid_estimator`

## Requirements
- R1: While reset is asserted and just after it, est_out equals init_est, est_valid is 0 and level_out is NUM_LEVELS-1. Both histories and both running sums are cleared to zero.
- R2: est_valid is high in exactly the cycle after each cycle in which wl_valid is high, and low in every other cycle.
- R3: On each strobe the error is e = wl_actual - est_out. In mode 2'b00 (mode 2'b11 behaves the same way), the next estimate is est_out + C. C = (kp*e + ((ki*S) >>> wi) + ((kd*(e - eD)) >>> wd)) >>> 4, where kp, ki and kd are unsigned gains with 4 fractional bits and >>> is a flooring arithmetic shift.
- R4: S is the sum of the errors of the latest 2^wi strobes, the current one included. Strobes before reset count as zero. wi is int_win_lg limited to at most 4, and it must stay constant between resets.
- R5: eD is the error of the strobe 2^wd strobes earlier, or zero when no such strobe has happened since reset. wd is der_win_lg limited to at most 4.
- R6: A next estimate below zero becomes 0. One above 2^WL_W-1 becomes 2^WL_W-1.
- R7: In mode 2'b01, the next estimate is the sum of the measured workloads of the latest 2^wi strobes (zeros before reset), shifted right by wi.
- R8: In mode 2'b10, the next estimate is est_out + (e >>> ewa_lg). It lies between the previous estimate and the measured workload.
- R9: On each strobe, level_out becomes the lowest k in 0..NUM_LEVELS-1 for which (k+1)*FREQ_STEP*deadline is at least the new estimate. If there is no such k, it becomes NUM_LEVELS-1. deadline is sampled in the strobe cycle.
- R10: Between strobes, est_out and level_out hold their values whatever happens on deadline, the gains, the windows or the mode.
- R11: Both histories record every strobe in every mode, so a mode change takes effect at the next strobe using the full past.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wl_valid | input | 1 | Strobe: a frame's measured workload is present |
| wl_actual | input | WL_W | Measured cycle count of the finished frame |
| mode | input | 2 | Filter select: 00 three-term, 01 window average, 10 exponential |
| kp | input | GAIN_W | Proportional gain, 4 fractional bits |
| ki | input | GAIN_W | Window-sum gain, 4 fractional bits |
| kd | input | GAIN_W | Difference gain, 4 fractional bits |
| int_win_lg | input | WIN_W | log2 of the sum/average window |
| der_win_lg | input | WIN_W | log2 of the difference span |
| ewa_lg | input | WIN_W | Shift of the exponential smoother |
| init_est | input | WL_W | Estimate loaded by reset |
| deadline | input | DL_W | Frame deadline in level-rate time units |
| est_out | output | WL_W | Current workload estimate |
| est_valid | output | 1 | New estimate present (one cycle) |
| level_out | output | LVL_W | Selected frequency/voltage level index |

## Verification
A wrong history slot or a drifting running sum does not show at once. It appears at the first strobe whose window reaches the bad entry, which is up to 2^wi strobes later for the window sum. After that the estimate error keeps compounding, because each forecast feeds the next error. A wrong write pointer shifts the derivative term by whole frames and appears as soon as the difference span wraps. A level-map fault appears in the est_valid cycle of the first estimate near a capacity boundary, so the bench places estimates exactly on and just past those boundaries.

// File: rtl/wl_est_pkg.sv
package wl_est_pkg;

  localparam int ACC_W = 48;

  typedef enum logic [1:0] {
    MODE_PID = 2'b00,
    MODE_MA  = 2'b01,
    MODE_EWA = 2'b10,
    MODE_ALT = 2'b11
  } est_mode_e;

  // Three-term correction: proportional + windowed sum + span difference,
  // with gains in fixed point carrying frac fractional bits.
  function automatic logic signed [ACC_W-1:0] pid_corr(
    input logic signed [ACC_W-1:0] g_p,
    input logic signed [ACC_W-1:0] g_i,
    input logic signed [ACC_W-1:0] g_d,
    input logic signed [ACC_W-1:0] err,
    input logic signed [ACC_W-1:0] err_sum,
    input logic signed [ACC_W-1:0] err_dif,
    input int unsigned             sh_i,
    input int unsigned             sh_d,
    input int unsigned             frac
  );
    logic signed [ACC_W-1:0] t_p, t_i, t_d, tot;
    t_p = g_p * err;
    t_i = (g_i * err_sum) >>> sh_i;
    t_d = (g_d * err_dif) >>> sh_d;
    tot = t_p + t_i + t_d;
    return tot >>> frac;
  endfunction

endpackage

// File: rtl/wl_hist_ring.sv
module wl_hist_ring #(
  parameter int W     = 17,
  parameter int DEPTH = 16,
  parameter int NTAPS = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [W-1:0]                   din,
  input  logic [NTAPS-1:0][AW-1:0]       tap_dist,
  output logic [NTAPS-1:0][W-1:0]        tap_q
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[wp] <= din;
      wp      <= wp + 1'b1;
    end
  end

  // Distance d reads the entry written d pushes ago; 0 means DEPTH.
  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    logic [AW-1:0] rd_idx;
    assign rd_idx   = wp - tap_dist[t];
    assign tap_q[t] = mem[rd_idx];
  end

endmodule

// File: rtl/wl_level_map.sv
module wl_level_map #(
  parameter int WL_W       = 16,
  parameter int DL_W       = 12,
  parameter int NUM_LEVELS = 6,
  parameter int FREQ_STEP  = 64,
  localparam int LVL_W     = $clog2(NUM_LEVELS),
  localparam int CAP_W     = DL_W + $clog2(NUM_LEVELS * FREQ_STEP) + 1,
  localparam int CMP_W     = (CAP_W > WL_W) ? CAP_W : WL_W
) (
  input  logic [WL_W-1:0]  est,
  input  logic [DL_W-1:0]  deadline,
  output logic [LVL_W-1:0] level
);

  logic [NUM_LEVELS-1:0] fits;

  for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_lvl
    logic [CMP_W-1:0] cap;
    assign cap     = CMP_W'(deadline) * CMP_W'((k + 1) * FREQ_STEP);
    assign fits[k] = (cap >= CMP_W'(est));
  end

  always_comb begin
    level = LVL_W'(NUM_LEVELS - 1);
    for (int k = NUM_LEVELS - 1; k >= 0; k--) begin
      if (fits[k]) level = LVL_W'(k);
    end
  end

endmodule

// File: rtl/wl_pid_estimator.sv
module wl_pid_estimator
  import wl_est_pkg::*;
#(
  parameter int WL_W       = 16,
  parameter int DL_W       = 12,
  parameter int NUM_LEVELS = 6,
  parameter int FREQ_STEP  = 64,
  parameter int HIST_DEPTH = 16,
  parameter int GAIN_W     = 8,
  parameter int GAIN_FRAC  = 4,
  localparam int HIST_AW   = $clog2(HIST_DEPTH),
  localparam int WIN_W     = $clog2(HIST_AW + 1),
  localparam int LVL_W     = $clog2(NUM_LEVELS),
  localparam int ERR_W     = WL_W + 1,
  localparam int ISUM_W    = ERR_W + HIST_AW + 1,
  localparam int WSUM_W    = WL_W + HIST_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wl_valid,
  input  logic [WL_W-1:0]   wl_actual,
  input  logic [1:0]        mode,
  input  logic [GAIN_W-1:0] kp,
  input  logic [GAIN_W-1:0] ki,
  input  logic [GAIN_W-1:0] kd,
  input  logic [WIN_W-1:0]  int_win_lg,
  input  logic [WIN_W-1:0]  der_win_lg,
  input  logic [WIN_W-1:0]  ewa_lg,
  input  logic [WL_W-1:0]   init_est,
  input  logic [DL_W-1:0]   deadline,
  output logic [WL_W-1:0]   est_out,
  output logic              est_valid,
  output logic [LVL_W-1:0]  level_out
);

  localparam logic signed [ACC_W-1:0] EST_MAX =
    $signed({{(ACC_W-WL_W){1'b0}}, {WL_W{1'b1}}});

  // ---------------- state ----------------
  logic [WL_W-1:0]          est_q;
  logic signed [ISUM_W-1:0] isum_q;
  logic [WSUM_W-1:0]        wsum_q;

  // ---------------- window selection ----------------
  logic [WIN_W-1:0]   wi_sel, wd_sel;
  logic [HIST_AW-1:0] dist_i, dist_d;

  assign wi_sel = (int_win_lg > WIN_W'(HIST_AW)) ? WIN_W'(HIST_AW) : int_win_lg;
  assign wd_sel = (der_win_lg > WIN_W'(HIST_AW)) ? WIN_W'(HIST_AW) : der_win_lg;
  assign dist_i = (wi_sel == WIN_W'(HIST_AW)) ? '0 : (HIST_AW'(1) << wi_sel);
  assign dist_d = (wd_sel == WIN_W'(HIST_AW)) ? '0 : (HIST_AW'(1) << wd_sel);

  // ---------------- error and histories ----------------
  logic signed [ERR_W-1:0] err_now;
  logic signed [ERR_W-1:0] err_old_i, err_old_d;
  logic [1:0][ERR_W-1:0]   err_taps;
  logic [1:0][HIST_AW-1:0] err_dist;
  logic [0:0][WL_W-1:0]    wl_taps;
  logic [0:0][HIST_AW-1:0] wl_dist;
  logic [WL_W-1:0]         wl_old;

  assign err_now = ERR_W'($signed({1'b0, wl_actual}) - $signed({1'b0, est_q}));
  assign err_dist = {dist_d, dist_i};
  assign wl_dist  = dist_i;

  wl_hist_ring #(.W(ERR_W), .DEPTH(HIST_DEPTH), .NTAPS(2)) u_err_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (wl_valid),
    .din      (err_now),
    .tap_dist (err_dist),
    .tap_q    (err_taps)
  );

  wl_hist_ring #(.W(WL_W), .DEPTH(HIST_DEPTH), .NTAPS(1)) u_wl_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (wl_valid),
    .din      (wl_actual),
    .tap_dist (wl_dist),
    .tap_q    (wl_taps)
  );

  assign err_old_i = $signed(err_taps[0]);
  assign err_old_d = $signed(err_taps[1]);
  assign wl_old    = wl_taps[0];

  // ---------------- running sums (add newest, drop oldest) ----------------
  logic signed [ISUM_W-1:0] isum_nx;
  logic [WSUM_W-1:0]        wsum_nx;
  logic signed [ERR_W:0]    err_dif;

  assign isum_nx = isum_q + ISUM_W'(err_now) - ISUM_W'(err_old_i);
  assign wsum_nx = wsum_q + WSUM_W'(wl_actual) - WSUM_W'(wl_old);
  assign err_dif = (ERR_W+1)'(err_now) - (ERR_W+1)'(err_old_d);

  // ---------------- candidate estimates ----------------
  logic signed [ACC_W-1:0] est_acc, err_acc, corr_pid;
  logic signed [ACC_W-1:0] cand_pid, cand_ma, cand_ewa, cand_sel;

  assign est_acc  = $signed(ACC_W'(est_q));
  assign err_acc  = ACC_W'(err_now);
  assign corr_pid = pid_corr($signed(ACC_W'(kp)), $signed(ACC_W'(ki)), $signed(ACC_W'(kd)),
                             err_acc, ACC_W'(isum_nx), ACC_W'(err_dif),
                             int'(wi_sel), int'(wd_sel), GAIN_FRAC);
  assign cand_pid = est_acc + corr_pid;
  assign cand_ma  = $signed(ACC_W'(wsum_nx >> wi_sel));
  assign cand_ewa = est_acc + (err_acc >>> ewa_lg);

  always_comb begin
    unique case (est_mode_e'(mode))
      MODE_MA:  cand_sel = cand_ma;
      MODE_EWA: cand_sel = cand_ewa;
      default:  cand_sel = cand_pid;
    endcase
  end

  // ---------------- clamp (events named for the checker) ----------------
  logic            clamp_lo, clamp_hi;
  logic [WL_W-1:0] est_nx;

  assign clamp_lo = (cand_sel < 0);
  assign clamp_hi = (cand_sel > EST_MAX);
  assign est_nx   = clamp_lo ? '0 : (clamp_hi ? '1 : cand_sel[WL_W-1:0]);

  // ---------------- level quantisation ----------------
  logic [LVL_W-1:0] level_nx;

  wl_level_map #(.WL_W(WL_W), .DL_W(DL_W), .NUM_LEVELS(NUM_LEVELS),
                 .FREQ_STEP(FREQ_STEP)) u_level (
    .est      (est_nx),
    .deadline (deadline),
    .level    (level_nx)
  );

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_q     <= init_est;
      isum_q    <= '0;
      wsum_q    <= '0;
      est_valid <= 1'b0;
      level_out <= LVL_W'(NUM_LEVELS - 1);
    end else begin
      est_valid <= wl_valid;
      if (wl_valid) begin
        est_q     <= est_nx;
        isum_q    <= isum_nx;
        wsum_q    <= wsum_nx;
        level_out <= level_nx;
      end
    end
  end

  assign est_out = est_q;

endmodule

// File: rtl/wl_pid_estimator_chk.sv
module wl_pid_estimator_chk #(
  parameter int WL_W       = 16,
  parameter int DL_W       = 12,
  parameter int NUM_LEVELS = 6,
  parameter int FREQ_STEP  = 64,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wl_valid,
  input logic [WL_W-1:0]  wl_actual,
  input logic [1:0]       mode,
  input logic [DL_W-1:0]  deadline,
  input logic [WL_W-1:0]  est_out,
  input logic             est_valid,
  input logic [LVL_W-1:0] level_out,
  input logic             clamp_lo,
  input logic             clamp_hi
);

  logic [DL_W-1:0] dl_seen;
  logic            lvl_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dl_seen <= '0;
    else if (wl_valid) dl_seen <= deadline;
  end

  always_comb begin
    longint cap_here, cap_below;
    cap_here  = (longint'(level_out) + 1) * FREQ_STEP * longint'(dl_seen);
    cap_below = longint'(level_out) * FREQ_STEP * longint'(dl_seen);
    lvl_ok = (int'(level_out) < NUM_LEVELS)
          && ((int'(level_out) == NUM_LEVELS - 1) || (cap_here >= longint'(est_out)))
          && ((level_out == '0) || (cap_below < longint'(est_out)));
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wl_valid |=> est_valid);

  assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wl_valid |=> !est_valid);

  assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wl_valid |=> ($stable(est_out) && $stable(level_out)));

  assert_clamp_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_valid && clamp_lo) |=> (est_out == '0));

  assert_clamp_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_valid && clamp_hi) |=> (est_out == '1));

  assert_level_fit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> lvl_ok);

  assert_ewa_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_valid && mode == 2'b10) |=>
      (((est_out >= $past(est_out)) && (est_out <= $past(wl_actual))) ||
       ((est_out <= $past(est_out)) && (est_out >= $past(wl_actual)))));

endmodule

bind wl_pid_estimator wl_pid_estimator_chk #(
  .WL_W(WL_W), .DL_W(DL_W), .NUM_LEVELS(NUM_LEVELS), .FREQ_STEP(FREQ_STEP)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wl_valid  (wl_valid),
  .wl_actual (wl_actual),
  .mode      (mode),
  .deadline  (deadline),
  .est_out   (est_out),
  .est_valid (est_valid),
  .level_out (level_out),
  .clamp_lo  (clamp_lo),
  .clamp_hi  (clamp_hi)
);

// File: tb/wl_pid_estimator_tb_top.sv
module wl_pid_estimator_tb_top;

  localparam int WL_W = 16;
  localparam int DL_W = 12;
  localparam int NL   = 6;
  localparam int FSTP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wl_valid = 1'b0;
  logic [WL_W-1:0] wl_actual = '0;
  logic [1:0] mode = 2'b00;
  logic [7:0] kp = 8'd16, ki = 8'd0, kd = 8'd0;
  logic [2:0] int_win_lg = 3'd0, der_win_lg = 3'd0, ewa_lg = 3'd1;
  logic [WL_W-1:0] init_est = '0;
  logic [DL_W-1:0] deadline = 12'd10;
  logic [WL_W-1:0] est_out;
  logic est_valid;
  logic [2:0] level_out;

  always #10 clk = ~clk;

  wl_pid_estimator dut_i (
    .clk(clk), .rst_n(rst_n), .wl_valid(wl_valid), .wl_actual(wl_actual),
    .mode(mode), .kp(kp), .ki(ki), .kd(kd), .int_win_lg(int_win_lg),
    .der_win_lg(der_win_lg), .ewa_lg(ewa_lg), .init_est(init_est),
    .deadline(deadline), .est_out(est_out), .est_valid(est_valid),
    .level_out(level_out)
  );

  typedef struct {
    longint est;
    longint lvl;
    string  rq;
  } exp_t;

  exp_t   sbq[$];
  longint m_est;
  longint eh[$];
  longint wh[$];
  int     n_chk = 0;
  int     n_bad = 0;
  bit     done  = 1'b0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic longint lvl_of(input longint e, input longint dl);
    for (int k = 0; k < NL; k++)
      if ((k + 1) * FSTP * dl >= e) return k;
    return NL - 1;
  endfunction

  function automatic int lim4(input int v);
    return (v > 4) ? 4 : v;
  endfunction

  task automatic do_reset(input int init);
    @(negedge clk);
    rst_n = 1'b0;
    init_est = WL_W'(init);
    m_est = init;
    eh.delete();
    wh.delete();
    repeat (3) @(negedge clk);
    chk(est_out == WL_W'(init), "R1 est during reset", est_out, init);
    rst_n = 1'b1;
    @(negedge clk);
    chk(est_out == WL_W'(init), "R1 est after reset", est_out, init);
    chk(est_valid == 1'b0, "R1 valid after reset", est_valid, 0);
    chk(level_out == 3'(NL - 1), "R1 level after reset", level_out, NL - 1);
  endtask

  // Driver: model the next estimate, push it, then strobe the design.
  task automatic send(input int a, input string rq);
    exp_t it;
    longint e, isum, eold, nx, wsum;
    int wi, wd, n;
    e = a - m_est;
    eh.push_back(e);
    wh.push_back(a);
    wi = lim4(int'(int_win_lg));
    wd = lim4(int'(der_win_lg));
    n = eh.size();
    isum = 0;
    wsum = 0;
    for (int j = 0; j < (1 << wi); j++) begin
      if (n - 1 - j >= 0) begin
        isum += eh[n - 1 - j];
        wsum += wh[n - 1 - j];
      end
    end
    eold = (n - 1 - (1 << wd) >= 0) ? eh[n - 1 - (1 << wd)] : 0;
    case (mode)
      2'b01:   nx = wsum >>> wi;
      2'b10:   nx = m_est + (e >>> ewa_lg);
      default: nx = m_est + ((longint'(kp) * e + ((longint'(ki) * isum) >>> wi)
                    + ((longint'(kd) * (e - eold)) >>> wd)) >>> 4);
    endcase
    if (nx < 0) nx = 0;
    if (nx > 65535) nx = 65535;
    m_est = nx;
    it.est = nx;
    it.lvl = lvl_of(nx, longint'(deadline));
    it.rq  = rq;
    sbq.push_back(it);
    @(negedge clk);
    wl_actual = WL_W'(a);
    wl_valid  = 1'b1;
    @(negedge clk);
    wl_valid  = 1'b0;
  endtask

  // Monitor: compares each new estimate against the queue head.
  always @(negedge clk) begin
    if (rst_n && est_valid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R2 unexpected valid", 1, 0);
      end else begin
        exp_t it;
        it = sbq.pop_front();
        chk(est_out == WL_W'(it.est), {it.rq, " estimate"}, est_out, it.est);
        chk(longint'(level_out) == it.lvl, {it.rq, " level R9"}, level_out, it.lvl);
      end
    end
  end

  task automatic drain();
    repeat (2) @(negedge clk);
    chk(sbq.size() == 0, "R2 missing valid", sbq.size(), 0);
  endtask

  initial begin
    // R1 reset state
    do_reset(1000);

    // R3 proportional only, unity then half gain; R9 boundaries at deadline 10
    mode = 2'b00; kp = 8'd16; ki = 8'd0; kd = 8'd0;
    send(1280, "R3 unity gain");
    send(1281, "R9 just past cap");
    send(640,  "R9 exact lowest cap");
    send(5000, "R9 above top cap");
    send(0,    "R9 zero estimate");
    kp = 8'd8;
    send(3000, "R3 half gain");
    send(100,  "R3 half gain down");
    send(2222, "R3 half gain odd");
    drain();

    // R10 hold while deadline and gain move
    begin
      logic [WL_W-1:0] e0;
      logic [2:0] l0;
      e0 = est_out; l0 = level_out;
      deadline = 12'd1; kp = 8'd200; mode = 2'b01;
      repeat (5) @(negedge clk);
      chk(est_out == e0, "R10 estimate held", est_out, e0);
      chk(level_out == l0, "R10 level held", level_out, l0);
      deadline = 12'd10; kp = 8'd8; mode = 2'b00;
    end

    // R4 windowed sum, window 4, wrapping past the window
    int_win_lg = 3'd2;
    do_reset(500);
    kp = 8'd4; ki = 8'd8; kd = 8'd0;
    for (int i = 0; i < 9; i++) send(800 + 137 * i, "R4 window sum");
    drain();

    // R4 full-depth window and limit of the window field
    int_win_lg = 3'd6;
    do_reset(700);
    kp = 8'd2; ki = 8'd3;
    for (int i = 0; i < 20; i++) send(((i * 911) % 3000) + 200, "R4 depth-16 window");
    drain();

    // R5 derivative span 2, then combined three-term
    int_win_lg = 3'd1;
    do_reset(1500);
    ki = 8'd0; kp = 8'd4; kd = 8'd12; der_win_lg = 3'd1;
    for (int i = 0; i < 6; i++) send(1500 + ((i % 2) ? 900 : -400), "R5 span diff");
    kp = 8'd10; ki = 8'd5; kd = 8'd6; der_win_lg = 3'd3;
    for (int i = 0; i < 12; i++) send(1000 + 250 * (i % 5), "R5 three-term");
    drain();

    // R6 clamps
    int_win_lg = 3'd0;
    do_reset(100);
    kp = 8'd32; ki = 8'd0; kd = 8'd0; der_win_lg = 3'd0;
    send(0, "R6 clamp floor");
    do_reset(60000);
    send(65535, "R6 clamp ceiling");
    drain();

    // R7 window average, R11 histories filled while in another mode
    int_win_lg = 3'd2;
    do_reset(0);
    mode = 2'b00; kp = 8'd16;
    send(400, "R11 pre-fill");
    send(800, "R11 pre-fill");
    mode = 2'b01;
    send(1200, "R7 average partial");
    send(1600, "R7 average full");
    send(2001, "R7 average slide");
    send(3, "R7 average slide");
    drain();

    // R8 exponential smoother
    do_reset(2000);
    mode = 2'b10; ewa_lg = 3'd2;
    send(3000, "R8 ewa up");
    send(1000, "R8 ewa down");
    send(1003, "R8 ewa rounding");
    ewa_lg = 3'd0;
    send(4321, "R8 ewa shift zero");
    drain();

    // R3 reserved mode acts as three-term
    mode = 2'b11; kp = 8'd24;
    send(2500, "R3 mode 11");
    drain();

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule